// File: doc/BRIEF.md
# Dual-Lane Registered Bus Transceiver

The block passes data between two ports, A and B, in either direction. Each direction has one storage register. Each port is modelled as a separate input, output and output-enable, so the block needs no tri-state nets. The data width is split into independent lanes of `LANE_W` bits each. Every lane has its own controls for each direction:

- a capture strobe,
- a select that picks live or stored data,
- an output enable.

A capture strobe that is high at a rising edge of `clk_i` loads that direction's register. The select and enable inputs have no effect on capture. When a direction's select is low, its output follows the live value seen on the opposite port. When the select is high, the output shows the stored register contents. The A-to-B enable is active high. The B-to-A enable is active low.

Each port has a resolved bus value. When the port is driven, this value is its own output; when it is not driven, it is the external input. Both the registers and the live paths use the resolved value.

When both directions are enabled and both are in live mode, the two ports would feed each other. The block breaks this loop with a keeper register. While the loop condition is false, the keeper follows the port A bus value every cycle. While the loop holds, both ports show the keeper value.

Top module: `dual_reg_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers and the keeper of every lane to zero.
- R2: A lane's A-to-B register loads the resolved A bus value at each clock edge where its `cap_ab_i` bit is high. The loading happens whatever the select and enable inputs are.
- R3: A lane's B-to-A register loads the resolved B bus value at each clock edge where its `cap_ba_i` bit is high. The loading happens whatever the select and enable inputs are.
- R4: `b_oe_o` of a lane equals its `oe_ab_i` bit (active high). While it is low, the lane's `b_o` bits are zero.
- R5: `a_oe_o` of a lane is the inverse of its `oe_ba_ni` bit (active low). While it is low, the lane's `a_o` bits are zero.
- R6: When a direction's select is 0, the driven output equals the opposite port's resolved value (live). When the select is 1, the driven output equals that direction's register (stored).
- R7: With A-to-B disabled and B-to-A disabled, neither port drives. Both registers still load the external inputs.
- R8: With B driven from the stored A register, a B-to-A capture copies that stored value into the B-to-A register.
- R9: Lanes are independent. Controls of one lane never change the outputs or registers of another lane.
- R10: While both directions are enabled and live, `a_o` and `b_o` of the lane both equal the keeper value, and the external inputs are ignored. The keeper holds the A bus value from the last cycle before the loop formed.
- R11: With its capture strobe low at a clock edge, a register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; capture strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | LANES*LANE_W | External value on port A |
| b_i | input | LANES*LANE_W | External value on port B |
| oe_ab_i | input | LANES | A-to-B enable per lane, active high |
| oe_ba_ni | input | LANES | B-to-A enable per lane, active low |
| sel_ab_i | input | LANES | A-to-B select per lane: 0 live, 1 stored |
| sel_ba_i | input | LANES | B-to-A select per lane: 0 live, 1 stored |
| cap_ab_i | input | LANES | A-to-B register capture strobe per lane |
| cap_ba_i | input | LANES | B-to-A register capture strobe per lane |
| a_o | output | LANES*LANE_W | Value driven onto port A, zero when not driving |
| a_oe_o | output | LANES | Port A drive enable per lane |
| b_o | output | LANES*LANE_W | Value driven onto port B, zero when not driving |
| b_oe_o | output | LANES | Port B drive enable per lane |

## Verification
A storage register holding a wrong value shows at the ports only when that direction selects storage mode with its output enabled. The same applies to a register loaded from the wrong source, such as the external input instead of the resolved bus. The outputs are combinational, so a fault becomes visible in the same cycle the select and enable change, and the bench reads every register back that way after each capture. A keeper that fails to track, or that changes during the loop, shows as the two ports disagreeing with the value set up one edge earlier. The lane cross-checks catch any mixing of lanes, since distinct bytes are captured into each lane.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_ab;
    logic oe_ba_n;
    logic sel_ab;
    logic sel_ba;
    logic cap_ab;
    logic cap_ba;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lane_ctrl_t        ctrl_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] a_o,
  output logic              a_oe_o,
  output logic [LANE_W-1:0] b_o,
  output logic              b_oe_o
);
  logic a_en, b_en, loop_w;
  logic [LANE_W-1:0] reg_ab, reg_ba, keep_q, a_bus, b_bus;

  assign a_en   = ~ctrl_i.oe_ba_n;
  assign b_en   = ctrl_i.oe_ab;
  assign loop_w = a_en & b_en & ~ctrl_i.sel_ab & ~ctrl_i.sel_ba;

  // resolved bus values; keeper stands in for the live-live feedback loop
  always_comb begin
    if (!a_en)              a_bus = a_i;
    else if (ctrl_i.sel_ba) a_bus = reg_ba;
    else if (!b_en)         a_bus = b_i;
    else if (ctrl_i.sel_ab) a_bus = reg_ab;
    else                    a_bus = keep_q;

    if (!b_en)              b_bus = b_i;
    else if (ctrl_i.sel_ab) b_bus = reg_ab;
    else if (!a_en)         b_bus = a_i;
    else if (ctrl_i.sel_ba) b_bus = reg_ba;
    else                    b_bus = keep_q;
  end

  xcvr_store #(.W(LANE_W)) u_ab (
    .clk_i, .rst_ni, .load_i(ctrl_i.cap_ab), .d_i(a_bus), .q_o(reg_ab)
  );
  xcvr_store #(.W(LANE_W)) u_ba (
    .clk_i, .rst_ni, .load_i(ctrl_i.cap_ba), .d_i(b_bus), .q_o(reg_ba)
  );
  xcvr_store #(.W(LANE_W)) u_keep (
    .clk_i, .rst_ni, .load_i(~loop_w), .d_i(a_bus), .q_o(keep_q)
  );

  assign a_oe_o = a_en;
  assign b_oe_o = b_en;
  assign a_o    = a_en ? a_bus : '0;
  assign b_o    = b_en ? b_bus : '0;
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES*LANE_W-1:0] a_i,
  input  logic [LANES*LANE_W-1:0] b_i,
  input  logic [LANES-1:0]        oe_ab_i,
  input  logic [LANES-1:0]        oe_ba_ni,
  input  logic [LANES-1:0]        sel_ab_i,
  input  logic [LANES-1:0]        sel_ba_i,
  input  logic [LANES-1:0]        cap_ab_i,
  input  logic [LANES-1:0]        cap_ba_i,
  output logic [LANES*LANE_W-1:0] a_o,
  output logic [LANES-1:0]        a_oe_o,
  output logic [LANES*LANE_W-1:0] b_o,
  output logic [LANES-1:0]        b_oe_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_ctrl_t ctrl;
    assign ctrl = '{oe_ab:   oe_ab_i[l],  oe_ba_n: oe_ba_ni[l],
                    sel_ab:  sel_ab_i[l], sel_ba:  sel_ba_i[l],
                    cap_ab:  cap_ab_i[l], cap_ba:  cap_ba_i[l]};

    xcvr_lane #(.LANE_W(LANE_W)) u_lane (
      .clk_i,
      .rst_ni,
      .ctrl_i (ctrl),
      .a_i    (a_i[l*LANE_W +: LANE_W]),
      .b_i    (b_i[l*LANE_W +: LANE_W]),
      .a_o    (a_o[l*LANE_W +: LANE_W]),
      .a_oe_o (a_oe_o[l]),
      .b_o    (b_o[l*LANE_W +: LANE_W]),
      .b_oe_o (b_oe_o[l])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [LANES*LANE_W-1:0] a_i,
  input logic [LANES*LANE_W-1:0] b_i,
  input logic [LANES-1:0]        oe_ab_i,
  input logic [LANES-1:0]        oe_ba_ni,
  input logic [LANES-1:0]        sel_ab_i,
  input logic [LANES-1:0]        sel_ba_i,
  input logic [LANES-1:0]        cap_ab_i,
  input logic [LANES-1:0]        cap_ba_i,
  input logic [LANES*LANE_W-1:0] a_o,
  input logic [LANES-1:0]        a_oe_o,
  input logic [LANES*LANE_W-1:0] b_o,
  input logic [LANES-1:0]        b_oe_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    p_b_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !b_oe_o[l] |-> b_o[l*LANE_W +: LANE_W] == '0);

    p_a_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !a_oe_o[l] |-> a_o[l*LANE_W +: LANE_W] == '0);

    p_live_ab_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_oe_o[l] && !sel_ab_i[l] && oe_ba_ni[l])
      |-> b_o[l*LANE_W +: LANE_W] == a_i[l*LANE_W +: LANE_W]);

    p_live_ba_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_oe_o[l] && !sel_ba_i[l] && !oe_ab_i[l])
      |-> a_o[l*LANE_W +: LANE_W] == b_i[l*LANE_W +: LANE_W]);

    p_store_ab_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(cap_ab_i[l] && oe_ba_ni[l]) && sel_ab_i[l] && oe_ab_i[l])
      |-> b_o[l*LANE_W +: LANE_W] == $past(a_i[l*LANE_W +: LANE_W]));

    p_loop_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && oe_ab_i[l] && !oe_ba_ni[l] && !sel_ab_i[l] && !sel_ba_i[l]
       && $past(oe_ab_i[l] && !oe_ba_ni[l] && !sel_ab_i[l] && !sel_ba_i[l]))
      |-> $stable(b_o[l*LANE_W +: LANE_W])
          && a_o[l*LANE_W +: LANE_W] == b_o[l*LANE_W +: LANE_W]);
  end
endmodule

bind dual_reg_xcvr xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_dual_reg_xcvr.sv
module sim_dual_reg_xcvr;
  localparam int LANES = 2;
  localparam int LANE_W = 8;
  localparam int W = LANES * LANE_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, a_o, b_o;
  logic [LANES-1:0] oe_ab_i = '0, oe_ba_ni = '1, sel_ab_i = '0, sel_ba_i = '0;
  logic [LANES-1:0] cap_ab_i = '0, cap_ba_i = '0, a_oe_o, b_oe_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dual_reg_xcvr #(.LANES(LANES), .LANE_W(LANE_W)) u0 (.*);

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg(logic [1:0] oab, logic [1:0] oban, logic [1:0] sab, logic [1:0] sba);
    oe_ab_i = oab; oe_ba_ni = oban; sel_ab_i = sab; sel_ba_i = sba;
    #1;
  endtask

  task automatic tick(logic [1:0] cab, logic [1:0] cba);
    cap_ab_i = cab; cap_ba_i = cba;
    @(posedge clk_i); #1;
    cap_ab_i = '0; cap_ba_i = '0;
    #0.5;
  endtask

  // read back both registers through storage mode
  task automatic peek(string req, logic [W-1:0] exp_ab, logic [W-1:0] exp_ba);
    cfg(2'b11, 2'b11, 2'b11, 2'b00);
    chk(req, b_o, exp_ab);
    cfg(2'b00, 2'b00, 2'b00, 2'b11);
    chk(req, a_o, exp_ba);
  endtask

  task automatic t_reset;
    cfg(2'b11, 2'b00, 2'b11, 2'b11);
    chk("R1 b_o", b_o, '0);
    chk("R1 a_o", a_o, '0);
    chk("R4 b_oe", {14'd0, b_oe_o}, 16'h3);
    chk("R5 a_oe", {14'd0, a_oe_o}, 16'h3);
  endtask

  task automatic t_isolation;
    a_i = 16'h5A3C; b_i = 16'hA5C3;
    cfg(2'b00, 2'b11, 2'b00, 2'b00);
    chk("R7 R4 b_o", b_o, '0);
    chk("R7 R5 a_o", a_o, '0);
    chk("R4 b_oe", {14'd0, b_oe_o}, '0);
    chk("R5 a_oe", {14'd0, a_oe_o}, '0);
    tick(2'b11, 2'b11);
    a_i = 16'h0F0F; b_i = 16'hFFFF;
    peek("R7 R2 R3", 16'h5A3C, 16'hA5C3);
  endtask

  task automatic t_no_strobe;
    a_i = 16'h1234; b_i = 16'h4321;
    cfg(2'b00, 2'b11, 2'b00, 2'b00);
    tick(2'b00, 2'b00);
    peek("R11", 16'h5A3C, 16'hA5C3);
  endtask

  task automatic t_live_and_capture;
    a_i = 16'h1122;
    cfg(2'b11, 2'b11, 2'b00, 2'b11);
    chk("R6 live ab", b_o, 16'h1122);
    tick(2'b11, 2'b00);
    a_i = 16'h9999; #1;
    chk("R6 live ab follow", b_o, 16'h9999);
    cfg(2'b11, 2'b11, 2'b11, 2'b11);
    chk("R2 R6 stored ab", b_o, 16'h1122);
    b_i = 16'h3344;
    cfg(2'b00, 2'b00, 2'b11, 2'b00);
    chk("R6 live ba", a_o, 16'h3344);
    tick(2'b00, 2'b11);
    b_i = 16'h0000;
    cfg(2'b00, 2'b00, 2'b11, 2'b11);
    chk("R3 R6 stored ba", a_o, 16'h3344);
  endtask

  task automatic t_copy_both;
    cfg(2'b11, 2'b11, 2'b11, 2'b00);
    b_i = 16'hDEAD; #1;
    chk("R8 drive stored", b_o, 16'h1122);
    tick(2'b00, 2'b11);
    peek("R8 copy", 16'h1122, 16'h1122);
  endtask

  task automatic t_lanes;
    a_i = 16'hBEEF; b_i = 16'hCAFE;
    cfg(2'b00, 2'b11, 2'b00, 2'b00);
    tick(2'b10, 2'b01);
    cfg(2'b10, 2'b10, 2'b10, 2'b01);
    chk("R9 b_o mixed", b_o, 16'hBE00);
    chk("R9 a_o mixed", a_o, 16'h00FE);
    chk("R9 oe mixed", {a_oe_o, b_oe_o, 12'd0}, {2'b01, 2'b10, 12'd0});
    peek("R9 regs", 16'hBE22, 16'h11FE);
  endtask

  task automatic t_loop;
    a_i = 16'h7777; b_i = 16'h0000;
    cfg(2'b11, 2'b11, 2'b00, 2'b00);
    tick(2'b00, 2'b00);
    chk("R10 pre", b_o, 16'h7777);
    cfg(2'b11, 2'b00, 2'b00, 2'b00);
    chk("R10 a_o", a_o, 16'h7777);
    chk("R10 b_o", b_o, 16'h7777);
    a_i = 16'h0000; b_i = 16'hFFFF;
    tick(2'b00, 2'b00);
    tick(2'b00, 2'b00);
    chk("R10 a_o held", a_o, 16'h7777);
    chk("R10 b_o held", b_o, 16'h7777);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #0.5;
    t_reset();
    t_isolation();
    t_no_strobe();
    t_live_and_capture();
    t_copy_both();
    t_lanes();
    t_loop();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule